// File: doc/BRIEF.md
# Mixed Sticky and Live Event Status Block with Interrupt

This block gathers a vector of event conditions from a communications controller and presents them to a host as a small set of 8-bit status registers. Each bit position is fixed at build time as either sticky or live. A sticky bit captures the rising edge of its event and holds it until the host clears it. A live bit simply mirrors the present level of its event.

The host reaches the block through a plain strobe port. A read returns data one cycle later. A write to a status register clears the sticky bits whose positions carry a 1 in the written byte, and never disturbs the live bits. Every status register has its own mask register. A sticky bit whose mask bit is 0 pulls the shared active-low interrupt output low. The output goes high again only when no unmasked sticky bit is pending in any status register.

With the default parameters the address map is: address 0 is status register 0 (events 7:0), address 1 is status register 1 (events 15:8), address 2 is mask register 0 and address 3 is mask register 1. In each status register, bits 5:0 are sticky and bits 7:6 are live.

Top module: `status_irq_ctrl`

## Requirements
- R1: After reset, both status registers read 0x00, both mask registers read 0xFF, and irq_n_o is 1.
- R2: A 0-to-1 change on the event of a sticky bit sets that bit, and the bit still reads 1 after the event has gone back to 0.
- R3: A sticky bit stays at 1 until the host writes a byte with a 1 in that bit position to its status register. Writing 0 in that position leaves the bit unchanged.
- R4: After a sticky bit is cleared while its event is still 1, the bit stays 0. It sets again only when the event falls and then rises again.
- R5: A live bit (bits 7:6) always reads the level of its event at the read cycle, keeps no history, and host writes have no effect on it.
- R6: If an event rising edge and a host clear of the same sticky bit happen in the same cycle, the bit ends up at 1.
- R7: A pending sticky bit whose mask bit is 0 drives irq_n_o to 0 in the cycle after the bit sets.
- R8: A sticky bit whose mask bit is 1 still latches but does not drive irq_n_o. If its mask bit is later written to 0 while it is still pending, irq_n_o goes to 0 in the cycle after the mask write.
- R9: irq_n_o returns to 1 only when no unmasked sticky bit is pending in any status register. Clearing the pending bit of one register while another register's bit is pending keeps irq_n_o at 0.
- R10: When rd_en_i is 1, rdata_o presents the addressed register one cycle later, together with a one-cycle rd_valid_o pulse. Mask registers read back the value written.
- R11: Live bits never drive irq_n_o, whether their mask bits are set or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event levels, 8 per status register |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data (clear bits or mask value) |
| rdata_o | output | 8 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_n_o | output | 1 | Shared active-low interrupt |

## Verification
The hardest case to reach from the ports is a rising edge that arrives in the very cycle the host clears the same bit. The stimulus reaches it by driving the event edge and the write strobe on the same falling clock edge, with the event held low beforehand. A second difficult case is a condition that is still active after a clear: the bench holds the event high across the clear and then reads the bit back before and after a fresh edge. The interrupt combine across registers is reached by leaving one unmasked bit pending in each register and clearing them one at a time.

// File: rtl/sts_pkg.sv
package sts_pkg;
  // Number of upper bits per status register that are live by default
  localparam int LIVE_TOP_BITS = 2;

  typedef enum logic [0:0] {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } sel_kind_e;

  // Default sticky map for one register: low bits sticky, top bits live
  function automatic logic [7:0] default_sticky_byte();
    return 8'hFF >> LIVE_TOP_BITS;
  endfunction
endpackage

// File: rtl/sts_bit_bank.sv
module sts_bit_bank #(
  parameter int          W      = 8,
  parameter logic [W-1:0] STICKY = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] sticky_q;
  logic [W-1:0] rise;

  assign rise = evt_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= evt_i;
      // an edge in the same cycle as a clear wins
      sticky_q <= ((sticky_q & ~clr_i) | rise) & STICKY;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      assign status_o[i] = sticky_q[i];
    end else begin : g_live
      assign status_o[i] = evt_i[i];
    end
  end

  assign pend_o = sticky_q;

  // sticky bits hold unless cleared
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(sticky_q) & ~$past(clr_i) & ~sticky_q) == '0));

  // a rising edge always leaves the sticky bit set, even against a clear
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt_i) & ~$past(prev_q) & STICKY & ~sticky_q) == '0));

  // a bit only turns on because of a fresh edge
  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_q & ~$past(sticky_q) & ~($past(evt_i) & ~$past(prev_q))) == '0));
endmodule

// File: rtl/sts_mask_reg.sv
module sts_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)       mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end

  assert_mask_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/sts_host_port.sv
module sts_host_port #(
  parameter int NREG   = 2,
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [NREG*W-1:0] status_i,
  input  logic [NREG*W-1:0] mask_i,
  output logic [NREG*W-1:0] clr_o,
  output logic [NREG-1:0]   mask_we_o,
  output logic [W-1:0]      rdata_o,
  output logic              rd_valid_o
);
  import sts_pkg::*;

  sel_kind_e       kind;
  logic [W-1:0]    rd_mux;
  int unsigned     idx;

  always_comb begin
    idx = 32'(addr_i);
    kind = (idx >= NREG) ? SEL_MASK : SEL_STATUS;
    if (kind == SEL_MASK) idx = idx - NREG;
  end

  always_comb begin
    clr_o     = '0;
    mask_we_o = '0;
    rd_mux    = '0;
    for (int r = 0; r < NREG; r++) begin
      if (idx == r) begin
        if (kind == SEL_STATUS) begin
          rd_mux = status_i[r*W +: W];
          if (wr_en_i) clr_o[r*W +: W] = wdata_i;
        end else begin
          rd_mux = mask_i[r*W +: W];
          if (wr_en_i) mask_we_o[r] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (!rd_valid_o && $stable(rdata_o)));
  assert_one_mask_we_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_we_o));
endmodule

// File: rtl/sts_irq_combine.sv
module sts_irq_combine #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_n_o
);
  logic any_open;
  assign any_open = |(pend_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~any_open;
  end
endmodule

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl #(
  parameter int NREG   = 2,
  parameter int REG_W  = 8,
  parameter logic [NREG*REG_W-1:0] STICKY_MAP = {NREG{sts_pkg::default_sticky_byte()}},
  localparam int NBITS  = NREG * REG_W,
  localparam int ADDR_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBITS-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rd_valid_o,
  output logic              irq_n_o
);
  logic [NBITS-1:0] status_flat;
  logic [NBITS-1:0] pend_flat;
  logic [NBITS-1:0] mask_flat;
  logic [NBITS-1:0] clr_flat;
  logic [NREG-1:0]  mask_we;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    sts_bit_bank #(
      .W      (REG_W),
      .STICKY (STICKY_MAP[r*REG_W +: REG_W])
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt_i[r*REG_W +: REG_W]),
      .clr_i    (clr_flat[r*REG_W +: REG_W]),
      .status_o (status_flat[r*REG_W +: REG_W]),
      .pend_o   (pend_flat[r*REG_W +: REG_W])
    );

    sts_mask_reg #(
      .W (REG_W)
    ) u_mask (
      .clk     (clk),
      .rst     (rst),
      .we_i    (mask_we[r]),
      .wdata_i (wdata_i),
      .mask_o  (mask_flat[r*REG_W +: REG_W])
    );
  end

  sts_host_port #(
    .NREG   (NREG),
    .W      (REG_W),
    .ADDR_W (ADDR_W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .status_i   (status_flat),
    .mask_i     (mask_flat),
    .clr_o      (clr_flat),
    .mask_we_o  (mask_we),
    .rdata_o    (rdata_o),
    .rd_valid_o (rd_valid_o)
  );

  sts_irq_combine #(
    .N (NBITS)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .pend_i  (pend_flat),
    .mask_i  (mask_flat),
    .irq_n_o (irq_n_o)
  );

  // interrupt follows pending state of banks and masks one cycle later
  assert_irq_low_R7: assert property (@(posedge clk) disable iff (rst)
    (|(pend_flat & ~mask_flat)) |=> !irq_n_o);
  assert_irq_release_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_flat & ~mask_flat)) |=> irq_n_o);
  // live positions never hold pending state
  assert_live_no_pend_R11: assert property (@(posedge clk) disable iff (rst)
    (pend_flat & ~STICKY_MAP) == '0);
endmodule

// File: tb/status_irq_ctrl_bench.sv
module status_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid;
  logic        irq_n;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  status_irq_ctrl u_status_irq_ctrl (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .rd_valid_o (rd_valid),
    .irq_n_o    (irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R10 actual=%02h expected=none (unexpected read)", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, rdata, e.data);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.data = exp;
    e.tag  = tag;
    exp_q.push_back(e);
    rd_en = 1'b1;
    addr  = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int b);
    @(negedge clk);
    evt[b] = 1'b1;
    @(negedge clk);
    evt[b] = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd(2'd0, 8'h00, "R1 status0");
    rd(2'd1, 8'h00, "R1 status1");
    rd(2'd2, 8'hFF, "R1 mask0");
    rd(2'd3, 8'hFF, "R1 mask1");

    // R2 edge latches, holds after event falls; masked so no irq (R8)
    pulse(0);
    tick(1);
    chk("R8 masked no irq", {7'd0, irq_n}, 8'h01);
    rd(2'd0, 8'h01, "R2 latched");

    // R3 write zero keeps, write one clears
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h01, "R3 zero write");
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h00, "R3 clear");

    // R4 persistent condition
    @(negedge clk); evt[1] = 1'b1;
    rd(2'd0, 8'h02, "R4 set");
    wr(2'd0, 8'h02);
    rd(2'd0, 8'h00, "R4 no reset while held");
    @(negedge clk); evt[1] = 1'b0;
    @(negedge clk); evt[1] = 1'b1;
    @(negedge clk); evt[1] = 1'b0;
    rd(2'd0, 8'h02, "R4 fresh edge");
    wr(2'd0, 8'h02);

    // R5 live bits
    @(negedge clk); evt[7] = 1'b1;
    rd(2'd0, 8'h80, "R5 live high");
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h80, "R5 write no effect");
    @(negedge clk); evt[7] = 1'b0;
    rd(2'd0, 8'h00, "R5 no history");
    @(negedge clk); evt[14] = 1'b1;
    rd(2'd1, 8'h40, "R5 live reg1");
    @(negedge clk); evt[14] = 1'b0;

    // R10 mask readback, R7 interrupt
    wr(2'd2, 8'hFE);
    rd(2'd2, 8'hFE, "R10 mask readback");
    pulse(0);
    tick(1);
    chk("R7 irq low", {7'd0, irq_n}, 8'h00);
    wr(2'd0, 8'h01);
    tick(1);
    chk("R9 irq released", {7'd0, irq_n}, 8'h01);

    // R11 live bit unmasked never interrupts
    wr(2'd2, 8'h3E);
    @(negedge clk); evt[7] = 1'b1; evt[6] = 1'b1;
    tick(3);
    chk("R11 live no irq", {7'd0, irq_n}, 8'h01);
    @(negedge clk); evt[7] = 1'b0; evt[6] = 1'b0;

    // R9 pending in both registers
    wr(2'd3, 8'hFB);
    pulse(0);
    pulse(10);
    tick(1);
    chk("R9 both pending", {7'd0, irq_n}, 8'h00);
    wr(2'd0, 8'h01);
    tick(1);
    chk("R9 still low", {7'd0, irq_n}, 8'h00);
    rd(2'd1, 8'h04, "R9 reg1 pending");
    wr(2'd1, 8'h04);
    tick(1);
    chk("R9 released", {7'd0, irq_n}, 8'h01);

    // R8 unmask a pending bit
    wr(2'd2, 8'hFF);
    pulse(3);
    tick(2);
    chk("R8 masked pending", {7'd0, irq_n}, 8'h01);
    rd(2'd0, 8'h08, "R8 still latches");
    wr(2'd2, 8'hF7);
    tick(1);
    chk("R8 unmask irq", {7'd0, irq_n}, 8'h00);
    wr(2'd0, 8'h08);
    tick(1);
    chk("R8 cleared", {7'd0, irq_n}, 8'h01);

    // R6 edge and clear in the same cycle
    @(negedge clk);
    evt[4] = 1'b1;
    wr_en  = 1'b1;
    addr   = 2'd0;
    wdata  = 8'h10;
    @(negedge clk);
    wr_en  = 1'b0;
    evt[4] = 1'b0;
    rd(2'd0, 8'h10, "R6 set wins");
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h00, "R6 cleared after");

    tick(3);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R10 actual=%0d expected=0 (reads outstanding)", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule